// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This peripheral holds two independent 32-bit down-counters behind a simple single-cycle register bus. Each channel is set up by writing its reload value and then a control word. A control write with both the start strobe and the run bit set copies the first reload value into the counter. The counter then decreases by one on every tick of its selected prescaled clock. When the count passes zero the channel raises a sticky underflow flag. In periodic mode it then reloads and keeps running. In single-shot mode it halts with the count at zero.

Each channel drives a level interrupt, which is its flag gated by its interrupt enable. It also drives an output pin. The pin rests at a programmable idle level while the channel is halted and flips at every underflow while the channel runs. Software can make a timestamp source from one channel: it loads all-ones into the count and reload registers and runs that channel periodically. The bitwise inverse of the live count then rises by one per tick.

The byte address space gives each channel a 16-byte window: channel 0 at 0x00 and channel 1 at 0x10. Inside a window, offset 0x0 is control, 0x4 is the live count, 0x8 is the active reload value and 0xC is a spare reload register that is only stored.

Top module: `tmr_dual`

## Requirements
- R1: After reset every register of both channels reads 0, and `irq` and `tout` are 0.
- R2: Word-aligned accesses decode the channel from address bit 4 and the register from bits [3:2], with 0x0 control, 0x4 count, 0x8 active reload and 0xC spare reload. Both reload registers read back what was written, separately for each channel.
- R3: Control bit 1 is the run bit and bit 0 is the start strobe. A control write with both bits set loads the active reload value into the count and starts the channel.
- R4: A running channel decrements once per tick. Control bits [7:6] select the tick rate: 0 gives clk/2, 1 gives clk/8, 2 gives clk/32 and 3 gives clk/64. With control bit 4 (reload) set, a tick at count 0 reloads the active value, so underflows are exactly (reload+1)*divider cycles apart.
- R5: With bit 4 clear, a tick at count 0 stops the channel. The count stays 0 and bit 1 reads back 0.
- R6: Control bit 2 is the underflow flag. An underflow sets it. A control write with bit 2 at 0 clears it, and writing 1 to bit 2 leaves it unchanged. An underflow in the same cycle as a clear leaves the flag set.
- R7: `irq[n]` is high while channel n has its flag set and control bit 3 (interrupt enable) set. It stays high until the flag is cleared.
- R8: The start strobe always reads back as 0.
- R9: A halted channel keeps its count unchanged.
- R10: With all-ones in the count and reload registers and reload enabled, the inverted count rises by one per tick.
- R11: While halted, `tout[n]` equals control bit 5. While running it starts at bit 5 and flips at every underflow.
- R12: Writing the count register loads the live count directly, and it reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq | output | 2 | Per-channel level interrupt |
| tout | output | 2 | Per-channel output pin |

## Verification
The assertions assume at most one register is written per cycle, so a count write and a control write never meet in one channel. They also take reset as released only through the internal synchronizer. The bench meets both by issuing single word-aligned accesses, each separated by a full clock. It checks underflow spacing only between consecutive pin edges, so the unknown prescaler phase at a start never shifts an expected value. Single reads taken right after a start allow at most one tick of drift.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NSEL    = 4;
  localparam int SEL_W   = 2;
  localparam int PRE_W   = 6;
  localparam int WIN_LSB = 4;
  localparam int DIV_LOG2 [NSEL] = '{1, 3, 5, 6};

  localparam int CSR_GO   = 0;
  localparam int CSR_RUN  = 1;
  localparam int CSR_FLG  = 2;
  localparam int CSR_IE   = 3;
  localparam int CSR_AUTO = 4;
  localparam int CSR_LVL  = 5;
  localparam int CSR_SEL  = 6;

  typedef enum logic [1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_RLA = 2'd2,
    REG_RLB = 2'd3
  } reg_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick_o
);
  logic [PRE_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << DIV_LOG2[i]) - 1);
    assign tick_o[i] = (div_q & MASK) == MASK;
  end

  // fastest tick never fires two cycles in a row
  p_half_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] tick_vec,
  input  logic            wr_csr,
  input  logic            wr_cnt,
  input  logic            wr_rla,
  input  logic            wr_rlb,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    csr_o,
  output logic [W-1:0]    cnt_o,
  output logic [W-1:0]    rla_o,
  output logic [W-1:0]    rlb_o,
  output logic            irq_o,
  output logic            pin_o
);
  logic             run_q, run_d, flg_q, flg_d, ie_q, ie_d;
  logic             auto_q, auto_d, lvl_q, lvl_d, tgl_q, tgl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [W-1:0]     cnt_q, cnt_d, rla_q, rla_d, rlb_q, rlb_d;
  logic             tick, wrap;

  assign tick = tick_vec[sel_q];
  assign wrap = run_q && tick && (cnt_q == '0);

  always_comb begin
    run_d = run_q; flg_d = flg_q; ie_d = ie_q; auto_d = auto_q;
    lvl_d = lvl_q; tgl_d = tgl_q; sel_d = sel_q;
    cnt_d = cnt_q; rla_d = rla_q; rlb_d = rlb_q;
    if (run_q && tick) begin
      if (cnt_q == '0) begin
        flg_d = 1'b1;
        tgl_d = ~tgl_q;
        if (auto_q) cnt_d = rla_q;
        else        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (wr_csr) begin
      run_d  = wdata[CSR_RUN];
      ie_d   = wdata[CSR_IE];
      auto_d = wdata[CSR_AUTO];
      lvl_d  = wdata[CSR_LVL];
      sel_d  = wdata[CSR_SEL +: SEL_W];
      flg_d  = (flg_q & wdata[CSR_FLG]) | wrap;
      if (wdata[CSR_RUN] && (wdata[CSR_GO] || !run_q))
        tgl_d = wdata[CSR_LVL];
      if (wdata[CSR_RUN] && wdata[CSR_GO])
        cnt_d = rla_q;
    end
    if (wr_cnt) cnt_d = wdata;
    if (wr_rla) rla_d = wdata;
    if (wr_rlb) rlb_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; flg_q <= 1'b0; ie_q <= 1'b0; auto_q <= 1'b0;
      lvl_q <= 1'b0; tgl_q <= 1'b0; sel_q <= '0;
      cnt_q <= '0; rla_q <= '0; rlb_q <= '0;
    end else begin
      run_q <= run_d; flg_q <= flg_d; ie_q <= ie_d; auto_q <= auto_d;
      lvl_q <= lvl_d; tgl_q <= tgl_d; sel_q <= sel_d;
      cnt_q <= cnt_d; rla_q <= rla_d; rlb_q <= rlb_d;
    end
  end

  always_comb begin
    csr_o = '0;
    csr_o[CSR_RUN]  = run_q;
    csr_o[CSR_FLG]  = flg_q;
    csr_o[CSR_IE]   = ie_q;
    csr_o[CSR_AUTO] = auto_q;
    csr_o[CSR_LVL]  = lvl_q;
    csr_o[CSR_SEL +: SEL_W] = sel_q;
  end
  assign cnt_o = cnt_q;
  assign rla_o = rla_q;
  assign rlb_o = rlb_q;
  assign irq_o = flg_q & ie_q;
  assign pin_o = run_q ? tgl_q : lvl_q;

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_csr && wdata[CSR_RUN] && wdata[CSR_GO] |=> run_q && cnt_q == $past(rla_q));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && auto_q && !wr_csr && !wr_cnt |=> run_q && cnt_q == $past(rla_q));
  p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !auto_q && !wr_csr && !wr_cnt |=> !run_q && cnt_q == '0);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flg_q);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q && !wr_csr |=> flg_q);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !wr_csr |=> irq_o);
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !wr_csr && !wr_cnt |=> $stable(cnt_q));
  p_pin_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && auto_q && !wr_csr |=> pin_o != $past(pin_o));
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] tout
);
  localparam int IDX_W = AW - WIN_LSB;

  logic [1:0]       sync_q;
  logic             rst_core_n;
  logic [NSEL-1:0]  ticks;
  logic             aligned;
  logic [IDX_W-1:0] ch_idx;
  reg_e             reg_sel;
  logic [DW-1:0]    csr_a [NCH];
  logic [DW-1:0]    cnt_a [NCH];
  logic [DW-1:0]    rla_a [NCH];
  logic [DW-1:0]    rlb_a [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_core_n = sync_q[1];

  assign aligned = bus_addr[1:0] == 2'b00;
  assign ch_idx  = bus_addr[AW-1:WIN_LSB];
  assign reg_sel = reg_e'(bus_addr[WIN_LSB-1:2]);

  tmr_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_o (ticks)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_w;
    assign hit_w = bus_en && bus_we && aligned && (ch_idx == IDX_W'(c));
    tmr_chan #(.W(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick_vec (ticks),
      .wr_csr   (hit_w && reg_sel == REG_CSR),
      .wr_cnt   (hit_w && reg_sel == REG_CNT),
      .wr_rla   (hit_w && reg_sel == REG_RLA),
      .wr_rlb   (hit_w && reg_sel == REG_RLB),
      .wdata    (bus_wdata),
      .csr_o    (csr_a[c]),
      .cnt_o    (cnt_a[c]),
      .rla_o    (rla_a[c]),
      .rlb_o    (rlb_a[c]),
      .irq_o    (irq[c]),
      .pin_o    (tout[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_en && !bus_we && aligned && ch_idx == IDX_W'(c)) begin
        case (reg_sel)
          REG_CSR: bus_rdata = csr_a[c];
          REG_CNT: bus_rdata = cnt_a[c];
          REG_RLA: bus_rdata = rla_a[c];
          default: bus_rdata = rlb_a[c];
        endcase
      end
    end
  end

  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> irq == '0 && tout == '0);
endmodule

// File: tb/tb_tmr_dual.sv
module tb_tmr_dual;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  irq, tout;

  tmr_dual dut (.*);

  always #5 clk = ~clk;

  typedef struct { string tag; logic [31:0] exp; logic [31:0] tol; } item_t;
  item_t       exp_q [$];
  logic [31:0] act_q [$];
  int iv_q0 [$];
  int iv_q1 [$];
  int compared = 0, mismatched = 0;
  int cyc = 0;
  bit armed [2];
  int last_t [2];
  logic [1:0] prev_tout = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, logic [31:0] tol);
    item_t it;
    it.tag = tag; it.exp = exp; it.tol = tol;
    exp_q.push_back(it);
    act_q.push_back(act);
  endtask

  // scoreboard monitor for register and port checks
  initial begin
    forever begin
      item_t it;
      logic [31:0] a, d;
      wait (act_q.size() > 0);
      it = exp_q.pop_front();
      a  = act_q.pop_front();
      d  = (a > it.exp) ? a - it.exp : it.exp - a;
      compared++;
      if (d > it.tol) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.tag, a, it.exp);
      end
    end
  end

  // scoreboard monitor for underflow spacing seen on the output pins (R4, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (tout[ch] !== prev_tout[ch]) begin
          if (armed[ch]) begin
            armed[ch] = 1'b0;
          end else if ((ch == 0 && iv_q0.size() > 0) || (ch == 1 && iv_q1.size() > 0)) begin
            int e, a;
            e = (ch == 0) ? iv_q0.pop_front() : iv_q1.pop_front();
            a = cyc - last_t[ch];
            compared++;
            if (a != e) begin
              mismatched++;
              $display("FAIL R4/R11 ch%0d interval: actual %0d expected %0d", ch, a, e);
            end
          end
          last_t[ch] = cyc;
        end
      end
      prev_tout = tout;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d, output int t);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; t = cyc;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp, logic [31:0] tol);
    logic [31:0] d;
    int t;
    rd(a, d, t);
    chk(tag, d, exp, tol);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] va, vb;
    int ta, tb;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    armed[0] = 1'b0; armed[1] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 ch0 ctrl", 5'h00, 32'h0, 0);
    rd_chk("R1 ch1 count", 5'h14, 32'h0, 0);
    chk("R1 irq", {30'b0, irq}, 32'h0, 0);
    chk("R1 tout", {30'b0, tout}, 32'h0, 0);

    // R2 spare reload registers per channel
    wr(5'h0C, 32'hA5A5_0F0F);
    wr(5'h1C, 32'h5A5A_F0F0);
    rd_chk("R2 ch0 spare", 5'h0C, 32'hA5A5_0F0F, 0);
    rd_chk("R2 ch1 spare", 5'h1C, 32'h5A5A_F0F0, 0);

    // R12 direct count load, channel isolation
    wr(5'h04, 32'h0000_1234);
    rd_chk("R12 ch0 count", 5'h04, 32'h0000_1234, 0);
    rd_chk("R12 ch1 count untouched", 5'h14, 32'h0, 0);

    // R4 / R11 periodic spacing on both channels at different rates
    wr(5'h18, 32'd9);
    wr(5'h08, 32'd3);
    rd_chk("R2 ch1 active reload", 5'h18, 32'd9, 0);
    armed[0] = 1'b1; armed[1] = 1'b1;
    wr(5'h10, 32'h1B);          // div2, reload, irq enable, run, start
    wr(5'h00, 32'h93);          // div32, reload, run, start
    iv_q1.push_back(20); iv_q1.push_back(20); iv_q1.push_back(20);
    iv_q0.push_back(128); iv_q0.push_back(128);
    wait (iv_q0.size() == 0 && iv_q1.size() == 0);

    // R8 start strobe reads 0; R6 flag set; R7 irq only where enabled
    rd_chk("R8 ch1 ctrl", 5'h10, 32'h1E, 0);
    rd_chk("R8 ch0 ctrl", 5'h00, 32'h96, 0);
    chk("R7 irq gated by enable", {30'b0, irq}, 32'h2, 0);

    // R6 / R7 flag write semantics
    wr(5'h10, 32'h0C);
    rd_chk("R6 write-1 keeps flag", 5'h10, 32'h0C, 0);
    chk("R7 irq held", {31'b0, irq[1]}, 32'h1, 0);
    wr(5'h10, 32'h08);
    rd_chk("R6 write-0 clears flag", 5'h10, 32'h08, 0);
    chk("R7 irq drops", {31'b0, irq[1]}, 32'h0, 0);
    wr(5'h10, 32'h0C);
    rd_chk("R6 write-1 no set", 5'h10, 32'h08, 0);

    // R9 halted count frozen, pin idle
    wr(5'h00, 32'h0);
    rd(5'h04, va, ta);
    repeat (300) @(negedge clk);
    rd_chk("R9 halted count", 5'h04, va, 0);
    chk("R11 idle low", {31'b0, tout[0]}, 32'h0, 0);

    // R11 idle polarity
    wr(5'h00, 32'h20);
    chk("R11 idle high", {31'b0, tout[0]}, 32'h1, 0);
    rd_chk("R11 ctrl level", 5'h00, 32'h20, 0);

    // R5 single shot at div8
    wr(5'h08, 32'd5);
    wr(5'h00, 32'h4B);
    repeat (200) @(negedge clk);
    rd_chk("R5 ctrl after shot", 5'h00, 32'h4C, 0);
    rd_chk("R5 count at zero", 5'h04, 32'h0, 0);
    chk("R7 irq after shot", {31'b0, irq[0]}, 32'h1, 0);
    chk("R11 pin back to idle", {31'b0, tout[0]}, 32'h0, 0);

    // R3 start loads the active reload
    wr(5'h08, 32'd1000);
    wr(5'h00, 32'hC3);
    rd_chk("R3 count loaded", 5'h04, 32'd1000, 1);
    rd_chk("R3 ctrl running", 5'h00, 32'hC2, 0);

    // R10 free-running timestamp
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h13);
    rd(5'h14, va, ta);
    repeat (100) @(negedge clk);
    rd(5'h14, vb, tb);
    chk("R10 inverted count rises", ~vb, ~va + 32'((tb - ta) / 2), 1);

    wait (act_q.size() == 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule